// File: doc/BRIEF.md
# Software Interrupt Generator

This block turns a single register write into inter-processor interrupts. A processor writes one 32-bit word to the trigger address. That word holds an 8-bit list of target processors and a 4-bit interrupt number. For every processor that exists and whose list bit is set, the block sets the pending bit for that interrupt number in that processor's own banked copy. Only interrupt numbers 0 to 15 can be raised this way. Their trigger behaviour is fixed: each accepted write is one edge event, and no configuration input can change that.

The pending banks sit inside the block, one 16-bit bank per processor. The block also drives a one-cycle strobe for each bit that a write moves from idle to pending. The downstream distributor uses that strobe to count new events. It uses the clear port to retire a pending bit once the interrupt has been taken.

Top module: `sgi_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every bit of `pend_o` and `set_stb_o` reads 0.
- R2: A write with `wr_en` high and `wr_addr` equal to `TRIG_ADDR` sets, one clock later, pending bit `pend_o[c*16+id]` for each processor c whose target bit `wr_data[16+c]` is 1. All other pending bits keep their values.
- R3: The interrupt number is `wr_data[3:0]`. Bits 15:4 and 31:24 of the written word have no effect.
- R4: Target bits `wr_data[16+c]` with c at or above `NUM_CPUS` have no effect.
- R5: A trigger write whose target field `wr_data[23:16]` is all zero changes no pending bit and raises no strobe.
- R6: `set_stb_o[c*16+id]` is high for exactly the one cycle after a write that moved that bit from 0 to 1. Writing to a bit that is already pending keeps it at 1 and raises no strobe.
- R7: A cycle with `wr_en` low, or with `wr_addr` different from `TRIG_ADDR`, sets no pending bit.
- R8: With `clr_en` high, bit `clr_cpu*16+clr_id` reads 0 one clock later. A clear naming a processor at or above `NUM_CPUS` changes nothing. When a write sets the same bit in the same cycle, the set wins and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write valid |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data: targets in 23:16, interrupt number in 3:0 |
| clr_en | input | 1 | Clear one pending bit |
| clr_cpu | input | 3 | Processor whose bank is cleared |
| clr_id | input | 4 | Interrupt number to clear |
| pend_o | output | NUM_CPUS*16 | Pending bits; processor c, number i at bit c*16+i |
| set_stb_o | output | NUM_CPUS*16 | One-cycle strobe per newly pending bit |

## Verification
A wrong bank index, a mis-sliced field or a broken decode does not stay hidden. It shows up on `pend_o` one clock after the offending write, in the wrong processor lane or the wrong bit position. A bad idle-to-pending comparison shows up in the same cycle as a missing or extra pulse on `set_stb_o`. The testbench sweeps every target list against every interrupt number, with unused bits scrambled. It clears one bit between writes, so that every write meets a mix of idle and pending bits. Any of these faults therefore differs from the reference model within one or two cycles of the write that exposes it.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int MAX_CPUS   = 8;
    localparam int NUM_IDS    = 16;
    localparam int ID_W       = 4;
    localparam int CPU_W      = 3;
    localparam int TGT_LSB    = 16;
    localparam int ID_LSB     = 0;

    typedef logic [NUM_IDS-1:0]  id_vec_t;
    typedef logic [MAX_CPUS-1:0] cpu_list_t;

    typedef struct packed {
        cpu_list_t        targets;
        logic [ID_W-1:0]  id;
    } trig_word_t;

    typedef struct packed {
        logic             hit;
        cpu_list_t        targets;
        id_vec_t          id_mask;
    } trig_req_t;

    function automatic trig_word_t unpack_trig(input logic [31:0] word);
        trig_word_t t;
        t.targets = word[TGT_LSB +: MAX_CPUS];
        t.id      = word[ID_LSB +: ID_W];
        return t;
    endfunction

    function automatic id_vec_t id_onehot(input logic [ID_W-1:0] id);
        id_vec_t v;
        v = '0;
        v[id] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
    import sgi_pkg::*;
#(
    parameter int                NUM_CPUS  = 4,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 12'hF00
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output trig_req_t         req
);
    trig_word_t word;
    cpu_list_t  live;

    assign word = unpack_trig(wr_data);

    // Keep only the lanes of processors that exist.
    generate
        for (genvar g = 0; g < MAX_CPUS; g++) begin : g_lane
            if (g < NUM_CPUS) begin : g_live
                assign live[g] = word.targets[g];
            end else begin : g_dead
                assign live[g] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        req.hit     = wr_en && (wr_addr == TRIG_ADDR) && (|live);
        req.targets = live;
        req.id_mask = id_onehot(word.id);
    end

endmodule

// File: rtl/sgi_bank.sv
module sgi_bank
    import sgi_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    set_req,
    input  id_vec_t set_mask,
    input  logic    clr_req,
    input  id_vec_t clr_mask,
    output id_vec_t pend,
    output id_vec_t stb
);
    id_vec_t pend_q;
    id_vec_t stb_q;
    id_vec_t set_v;
    id_vec_t clr_v;

    always_comb begin
        set_v = set_req ? set_mask : '0;
        clr_v = clr_req ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            stb_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_v) | set_v;
            stb_q  <= set_v & ~pend_q;
        end
    end

    assign pend = pend_q;
    assign stb  = stb_q;

endmodule

// File: rtl/sgi_gen.sv
module sgi_gen
    import sgi_pkg::*;
#(
    parameter int                NUM_CPUS  = 4,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 12'hF00
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [31:0]               wr_data,
    input  logic                      clr_en,
    input  logic [2:0]                clr_cpu,
    input  logic [3:0]                clr_id,
    output logic [NUM_CPUS*16-1:0]    pend_o,
    output logic [NUM_CPUS*16-1:0]    set_stb_o
);
    localparam int LANE_W = NUM_IDS;

    trig_req_t req;
    id_vec_t   clr_mask;

    sgi_decode #(
        .NUM_CPUS (NUM_CPUS),
        .ADDR_W   (ADDR_W),
        .TRIG_ADDR(TRIG_ADDR)
    ) u_decode (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .req    (req)
    );

    assign clr_mask = id_onehot(clr_id);

    generate
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
            logic    set_c;
            logic    clr_c;
            id_vec_t pend_c;
            id_vec_t stb_c;

            assign set_c = req.hit && req.targets[c];
            assign clr_c = clr_en && (clr_cpu == CPU_W'(c));

            sgi_bank u_bank (
                .clk     (clk),
                .rst     (rst),
                .set_req (set_c),
                .set_mask(req.id_mask),
                .clr_req (clr_c),
                .clr_mask(clr_mask),
                .pend    (pend_c),
                .stb     (stb_c)
            );

            assign pend_o[c*LANE_W +: LANE_W]    = pend_c;
            assign set_stb_o[c*LANE_W +: LANE_W] = stb_c;
        end
    endgenerate

endmodule

// File: rtl/sgi_gen_chk.sv
module sgi_gen_chk #(
    parameter int                NUM_CPUS  = 4,
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 12'hF00
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      wr_addr,
    input logic [31:0]            wr_data,
    input logic                   clr_en,
    input logic [2:0]             clr_cpu,
    input logic [3:0]             clr_id,
    input logic [NUM_CPUS*16-1:0] pend_o,
    input logic [NUM_CPUS*16-1:0] set_stb_o
);
    localparam int TOT  = NUM_CPUS * 16;
    localparam int IDXW = $clog2(TOT);

    logic            trig_hit;
    logic [7:0]      live_tgt;
    logic            clr_ok;
    logic [IDXW-1:0] clr_idx;

    always_comb begin
        trig_hit = wr_en && (wr_addr == TRIG_ADDR);
        live_tgt = '0;
        for (int c = 0; c < NUM_CPUS; c++) live_tgt[c] = wr_data[16+c];
        clr_ok  = clr_en && (int'(clr_cpu) < NUM_CPUS) && !trig_hit;
        clr_idx = IDXW'(clr_cpu) * IDXW'(16) + IDXW'(clr_id);
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (pend_o == '0) && (set_stb_o == '0));

    // R6
    stb_implies_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (set_stb_o & ~pend_o) == '0);

    // R6
    stb_only_new_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (set_stb_o & $past(pend_o)) == '0);

    // R7
    no_write_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        !trig_hit |=> (pend_o & ~$past(pend_o)) == '0);

    // R5
    empty_list_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_hit && live_tgt == '0) |=> (pend_o & ~$past(pend_o)) == '0 && set_stb_o == '0);

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        clr_ok |=> !pend_o[$past(clr_idx)]);

endmodule

bind sgi_gen sgi_gen_chk #(
    .NUM_CPUS (NUM_CPUS),
    .ADDR_W   (ADDR_W),
    .TRIG_ADDR(TRIG_ADDR)
) u_sgi_gen_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .clr_en   (clr_en),
    .clr_cpu  (clr_cpu),
    .clr_id   (clr_id),
    .pend_o   (pend_o),
    .set_stb_o(set_stb_o)
);

// File: tb/sgi_gen_bench.sv
module sgi_gen_bench;
    localparam int          N    = 4;
    localparam int          AW   = 12;
    localparam logic [11:0] TA   = 12'hF00;
    localparam int          TOT  = N * 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic            clr_en = 1'b0;
    logic [2:0]      clr_cpu = '0;
    logic [3:0]      clr_id = '0;
    logic [TOT-1:0]  pend_o;
    logic [TOT-1:0]  set_stb_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [TOT-1:0] m_pend = '0;

    always #10 clk = ~clk;

    sgi_gen #(.NUM_CPUS(N), .ADDR_W(AW), .TRIG_ADDR(TA)) u_sgi_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_en(clr_en), .clr_cpu(clr_cpu), .clr_id(clr_id),
        .pend_o(pend_o), .set_stb_o(set_stb_o)
    );

    task automatic check(input string req, input logic [TOT-1:0] act_p,
                         input logic [TOT-1:0] exp_p, input logic [TOT-1:0] act_s,
                         input logic [TOT-1:0] exp_s);
        checks++;
        if (act_p !== exp_p || act_s !== exp_s) begin
            fails++;
            $display("FAIL %s: pend=%h stb=%h expected pend=%h stb=%h",
                     req, act_p, act_s, exp_p, exp_s);
        end
    endtask

    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                        input logic ce, input logic [2:0] cc, input logic [3:0] ci,
                        input string req);
        logic [TOT-1:0] set_v;
        logic [TOT-1:0] clr_v;
        logic [TOT-1:0] exp_s;
        set_v = '0;
        clr_v = '0;
        if (we && a == TA)
            for (int c = 0; c < N; c++)
                if (d[16+c]) set_v[c*16 + int'(d[3:0])] = 1'b1;
        if (ce && int'(cc) < N) clr_v[int'(cc)*16 + int'(ci)] = 1'b1;
        exp_s  = set_v & ~m_pend;
        m_pend = (m_pend & ~clr_v) | set_v;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        clr_en = ce; clr_cpu = cc; clr_id = ci;
        @(negedge clk);
        wr_en = 1'b0; clr_en = 1'b0;
        check(req, pend_o, m_pend, set_stb_o, exp_s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held at zero during reset
        check("R1", pend_o, '0, set_stb_o, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", pend_o, '0, set_stb_o, '0);

        // R2: single target, single number
        step(1'b1, TA, 32'h0002_0005, 1'b0, 3'd0, 4'd0, "R2");
        // R6: repeat to an already pending bit, no strobe
        step(1'b1, TA, 32'h0002_0005, 1'b0, 3'd0, 4'd0, "R6");
        // R7: wrong address and disabled write ignored
        step(1'b1, TA + 12'h004, 32'h000F_0003, 1'b0, 3'd0, 4'd0, "R7");
        step(1'b0, TA, 32'h000F_0003, 1'b0, 3'd0, 4'd0, "R7");
        // R5: empty target list
        step(1'b1, TA, 32'hFF00_FFF7, 1'b0, 3'd0, 4'd0, "R5");
        // R4: only non-existent processors named
        step(1'b1, TA, 32'h00F0_0009, 1'b0, 3'd0, 4'd0, "R4");
        // R8: clear pending bit, then clear of a missing processor
        step(1'b0, TA, 32'h0, 1'b1, 3'd1, 4'd5, "R8");
        step(1'b0, TA, 32'h0, 1'b1, 3'd6, 4'd5, "R8");
        // R8: set and clear of the same bit together, set wins
        step(1'b1, TA, 32'h0001_0002, 1'b0, 3'd0, 4'd0, "R8");
        step(1'b1, TA, 32'h0001_0002, 1'b1, 3'd0, 4'd2, "R8");

        // R2 R3 R4 R6 R8: sweep every number against every list, junk in ignored bits
        for (int id = 0; id < 16; id++) begin
            for (int m = 0; m < 256; m++) begin
                logic [31:0] d;
                d = {8'(m * 37 + id), 8'(m), 12'(id * 291 + m * 7), 4'(id)};
                step(1'b1, TA, d, 1'b0, 3'd0, 4'd0, "R3");
                step(1'b0, TA, 32'h0, 1'b1, 3'(m ^ id), 4'(id + m), "R8");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule